// File: doc/BRIEF.md
# Cacheability Memory Type Resolver

This block takes a physical address range and returns the memory type that applies to it. The range is given as a start address and an exclusive end address. Software first programs a small set of registers through a one-cycle write port. These are a control word (default type and two enable bits), a table of 88 type bytes for the first mebibyte, a number of base/mask range pairs, and an optional high-memory limit. After that, each lookup request produces one registered result.

The answer can come from four places, in this order:

1. The fixed table, selected by the start address alone.
2. The programmed ranges, combined by a precedence rule.
3. The high-memory limit.
4. The default type.

Two reserved codes report problems. 0xFF means the unit is unprogrammed or switched off. 0xFE means a range only partly lies inside one of the programmed windows.

Top module: `memtype_resolver`

## Requirements
- R1: Until the control word (select 0) has been written after reset, or while both control enable bits 11 and 10 are clear, every lookup returns 0xFF.
- R2: A lookup presented with `req_valid` high yields its result on `res_type` one clock later, with `res_valid` high for exactly that cycle. `res_type` then holds until the next lookup.
- R3: When the fixed table is built in (HAVE_FIXED=1) and start is below 0x100000, the result is a fixed table entry chosen by the start address only:
  - 0x00000 to 0x7FFFF: 64 KiB granules, entries 0 to 7.
  - 0x80000 to 0xBFFFF: 16 KiB granules, entries 8 to 23.
  - 0xC0000 to 0xFFFFF: 4 KiB granules, entries 24 to 87.
  - Writing select 2+k loads entries 8k..8k+7, with byte j of the data going to entry 8k+j.
- R4: The control word holds the default type in bits 7:0, the fixed enable in bit 10 and the range enable in bit 11. With bit 11 clear, any lookup outside the fixed table returns the default type.
- R5: Range i has its base at select 32+2i and its mask at select 33+2i. It takes part only when mask bit 11 is set. Address bits 11:0 are excluded from its comparison, and its type is base bits 7:0.
- R6: The end address is exclusive: one is subtracted from it before any comparison.
- R7: If start and inclusive end disagree on matching any participating range, the result is 0xFE. This code takes priority over the limit and over later ranges.
- R8: If uncacheable (0) meets any other matching type, the result is uncacheable.
- R9: Write-back (6) overlapping write-through (4) resolves to write-through (4).
- R10: Any other pair of differing overlapping types resolves to uncacheable (0).
- R11: The limit sits at select 1 and keeps only bits 47:23. When the limit is non-zero, start is at or above 4 GiB, and the inclusive end is below the limit, the result is write-back (6). This check overrides a plain range match.
- R12: When no range matches, the default type is returned.
- R13: Out of reset, `res_valid` is 0 and `res_type` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Register select |
| wr_data | input | DATA_W | Register write data |
| req_valid | input | 1 | Lookup request strobe |
| req_start | input | ADDR_W | First byte address of the range |
| req_end | input | ADDR_W | Exclusive end address of the range |
| res_valid | output | 1 | Result strobe, one cycle after a request |
| res_type | output | 8 | Resolved type or error code |

## Verification
The hardest case is the ordering between the early exits in the range chain and the limit. The bench must build two situations: a lookup that straddles a window above 4 GiB while the limit would otherwise grant write-back, and a lookup where a single range match is overridden by the limit. It does this by reprogramming one range into high memory, setting the default to uncacheable so the limit's write-back is distinguishable, and probing both just inside and just outside the limit. A limit value with bits set below bit 23 shows that those bits are discarded.

// File: rtl/memtype_pkg.sv
package memtype_pkg;

   localparam logic [7:0] MT_UC      = 8'h00;
   localparam logic [7:0] MT_WC      = 8'h01;
   localparam logic [7:0] MT_WT      = 8'h04;
   localparam logic [7:0] MT_WP      = 8'h05;
   localparam logic [7:0] MT_WB      = 8'h06;
   localparam logic [7:0] MT_PARTIAL = 8'hFE;
   localparam logic [7:0] MT_OFF     = 8'hFF;

   localparam int FIX_ENTRIES   = 88;
   localparam int FIX_WORDS     = 11;
   localparam int PAGE_LSB      = 12;
   localparam int VALID_BIT     = 11;
   localparam int FIX_EN_BIT    = 10;
   localparam int VAR_EN_BIT    = 11;
   localparam int LIMIT_LSB     = 23;

   localparam int SEL_CTRL  = 0;
   localparam int SEL_LIMIT = 1;
   localparam int SEL_FIX0  = 2;
   localparam int SEL_VAR0  = 32;

   typedef struct packed {
      logic       done;   // final answer reached early
      logic       hit;    // at least one range matched
      logic [7:0] typ;
   } chain_t;

   function automatic chain_t chain_step(chain_t p, logic en, logic s_m,
                                         logic e_m, logic [7:0] cur);
      chain_t     n;
      logic [7:0] a;
      logic [7:0] b;
      n = p;
      a = p.typ;
      b = cur;
      if (!p.done && en) begin
         if (s_m != e_m) begin
            n.done = 1'b1;
            n.typ  = MT_PARTIAL;
         end else if (s_m) begin
            if (!p.hit) begin
               n.hit = 1'b1;
               n.typ = cur;
            end else if (a == MT_UC || b == MT_UC) begin
               n.done = 1'b1;
               n.typ  = MT_UC;
            end else begin
               if ((a == MT_WB && b == MT_WT) || (a == MT_WT && b == MT_WB)) begin
                  a = MT_WT;
                  b = MT_WT;
               end
               if (a != b) begin
                  n.done = 1'b1;
                  n.typ  = MT_UC;
               end else begin
                  n.typ = a;
               end
            end
         end
      end
      return n;
   endfunction

endpackage

// File: rtl/memtype_regs.sv
module memtype_regs
   import memtype_pkg::*;
#(
   parameter int ADDR_W  = 48,
   parameter int NUM_VAR = 8,
   parameter int SEL_W   = 6,
   parameter int DATA_W  = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [SEL_W-1:0]            wr_sel,
   input  logic [DATA_W-1:0]           wr_data,
   output logic                        configured,
   output logic [7:0]                  def_type,
   output logic                        fix_en,
   output logic                        var_en,
   output logic [ADDR_W-1:0]           limit,
   output logic [FIX_ENTRIES*8-1:0]    fix_flat,
   output logic [NUM_VAR*ADDR_W-1:0]   var_base,
   output logic [NUM_VAR*ADDR_W-1:0]   var_mask
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         configured <= 1'b0;
         def_type   <= '0;
         fix_en     <= 1'b0;
         var_en     <= 1'b0;
         limit      <= '0;
         fix_flat   <= '0;
         var_base   <= '0;
         var_mask   <= '0;
      end else if (wr_en) begin
         if (wr_sel == SEL_W'(SEL_CTRL)) begin
            configured <= 1'b1;
            def_type   <= wr_data[7:0];
            fix_en     <= wr_data[FIX_EN_BIT];
            var_en     <= wr_data[VAR_EN_BIT];
         end
         if (wr_sel == SEL_W'(SEL_LIMIT))
            limit <= {wr_data[ADDR_W-1:LIMIT_LSB], {LIMIT_LSB{1'b0}}};
         for (int k = 0; k < FIX_WORDS; k++)
            if (wr_sel == SEL_W'(SEL_FIX0 + k))
               fix_flat[k*64 +: 64] <= wr_data[63:0];
         for (int i = 0; i < NUM_VAR; i++) begin
            if (wr_sel == SEL_W'(SEL_VAR0 + 2*i))
               var_base[i*ADDR_W +: ADDR_W] <= wr_data[ADDR_W-1:0];
            if (wr_sel == SEL_W'(SEL_VAR0 + 2*i + 1))
               var_mask[i*ADDR_W +: ADDR_W] <= wr_data[ADDR_W-1:0];
         end
      end
   end

endmodule

// File: rtl/memtype_fixed.sv
module memtype_fixed
   import memtype_pkg::*;
#(
   parameter int ADDR_W = 48
) (
   input  logic [ADDR_W-PAGE_LSB-1:0] page_addr,
   input  logic [FIX_ENTRIES*8-1:0]   fix_flat,
   output logic                       in_fixed,
   output logic [7:0]                 fix_type
);

   logic [6:0] idx;

   always_comb begin
      if (!page_addr[7])
         idx = {4'd0, page_addr[6:4]};
      else if (!page_addr[6])
         idx = 7'd8 + {3'd0, page_addr[5:2]};
      else
         idx = 7'd24 + {1'b0, page_addr[5:0]};
   end

   assign in_fixed = (page_addr[ADDR_W-PAGE_LSB-1:8] == '0);
   assign fix_type = fix_flat[{idx, 3'b000} +: 8];

endmodule

// File: rtl/memtype_var_chain.sv
module memtype_var_chain
   import memtype_pkg::*;
#(
   parameter int ADDR_W  = 48,
   parameter int NUM_VAR = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         start_addr,
   input  logic [ADDR_W-1:0]         last_addr,
   input  logic [NUM_VAR*ADDR_W-1:0] var_base,
   input  logic [NUM_VAR*ADDR_W-1:0] var_mask,
   output chain_t                    chain_out
);

   localparam logic [ADDR_W-1:0] PAGE_KEEP = ~ADDR_W'((1 << PAGE_LSB) - 1);

   chain_t             st [NUM_VAR+1];
   logic [NUM_VAR-1:0] valid_bits;

   assign st[0] = '0;

   for (genvar i = 0; i < NUM_VAR; i++) begin : g_stage
      logic [ADDR_W-1:0] pm;
      logic [ADDR_W-1:0] bm;
      logic              s_m;
      logic              e_m;
      assign pm            = var_mask[i*ADDR_W +: ADDR_W] & PAGE_KEEP;
      assign bm            = var_base[i*ADDR_W +: ADDR_W] & pm;
      assign s_m           = ((start_addr & pm) == bm);
      assign e_m           = ((last_addr & pm) == bm);
      assign valid_bits[i] = var_mask[i*ADDR_W + VALID_BIT];
      assign st[i+1] = chain_step(st[i], valid_bits[i], s_m, e_m,
                                  var_base[i*ADDR_W +: 8]);
   end

   assign chain_out = st[NUM_VAR];

   // R7
   partial_needs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_out.done && chain_out.typ == MT_PARTIAL) |-> (valid_bits != '0));

   // R10
   early_exit_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chain_out.done |-> (chain_out.typ == MT_PARTIAL || chain_out.typ == MT_UC));

endmodule

// File: rtl/memtype_resolver.sv
module memtype_resolver
   import memtype_pkg::*;
#(
   parameter int ADDR_W     = 48,
   parameter int NUM_VAR    = 8,
   parameter bit HAVE_FIXED = 1'b1,
   parameter int SEL_W      = 6,
   parameter int DATA_W     = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_start,
   input  logic [ADDR_W-1:0] req_end,
   output logic              res_valid,
   output logic [7:0]        res_type
);

   localparam int SEL_NEEDED = SEL_VAR0 + 2*NUM_VAR;

   if (ADDR_W < 33 || ADDR_W > DATA_W) begin : g_bad_addr
      $error("ADDR_W must exceed 32 and fit in DATA_W");
   end
   if (DATA_W < 64) begin : g_bad_data
      $error("DATA_W must be at least 64");
   end
   if (NUM_VAR < 1 || SEL_NEEDED > (1 << SEL_W)) begin : g_bad_sel
      $error("NUM_VAR does not fit the select space");
   end

   logic                      configured;
   logic [7:0]                def_type;
   logic                      fix_en;
   logic                      var_en;
   logic [ADDR_W-1:0]         limit;
   logic [FIX_ENTRIES*8-1:0]  fix_flat;
   logic [NUM_VAR*ADDR_W-1:0] var_base;
   logic [NUM_VAR*ADDR_W-1:0] var_mask;
   logic [ADDR_W-1:0]         last_addr;
   logic                      in_fixed;
   logic [7:0]                fix_type;
   chain_t                    chain;
   logic                      high_start;
   logic [7:0]                result;

   memtype_regs #(
      .ADDR_W (ADDR_W), .NUM_VAR(NUM_VAR), .SEL_W(SEL_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .configured(configured),
      .def_type  (def_type),
      .fix_en    (fix_en),
      .var_en    (var_en),
      .limit     (limit),
      .fix_flat  (fix_flat),
      .var_base  (var_base),
      .var_mask  (var_mask)
   );

   assign last_addr = req_end - ADDR_W'(1);

   if (HAVE_FIXED) begin : g_fixed
      memtype_fixed #(.ADDR_W(ADDR_W)) u_fixed (
         .page_addr(req_start[ADDR_W-1:PAGE_LSB]),
         .fix_flat (fix_flat),
         .in_fixed (in_fixed),
         .fix_type (fix_type)
      );
   end else begin : g_nofixed
      assign in_fixed = 1'b0;
      assign fix_type = MT_UC;
   end

   memtype_var_chain #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_addr(req_start),
      .last_addr (last_addr),
      .var_base  (var_base),
      .var_mask  (var_mask),
      .chain_out (chain)
   );

   assign high_start = |req_start[ADDR_W-1:32];

   always_comb begin
      if (!configured || !(fix_en || var_en))
         result = MT_OFF;
      else if (in_fixed)
         result = fix_type;
      else if (!var_en)
         result = def_type;
      else if (chain.done)
         result = chain.typ;
      else if (limit != '0 && high_start && last_addr < limit)
         result = MT_WB;
      else if (chain.hit)
         result = chain.typ;
      else
         result = def_type;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_type  <= MT_OFF;
      end else begin
         res_valid <= req_valid;
         if (req_valid)
            res_type <= result;
      end
   end

   // R2
   resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);

   // R2
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(res_type));

   // R1
   unprogrammed_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !configured) |=> (res_type == MT_OFF));

   // R4
   default_when_ranges_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && configured && fix_en && !var_en && !in_fixed)
      |=> (res_type == $past(def_type)));

endmodule

// File: tb/memtype_resolver_bench.sv
module memtype_resolver_bench;

   localparam int AW = 48;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [5:0]    wr_sel = '0;
   logic [63:0]   wr_data = '0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_start = '0;
   logic [AW-1:0] req_end = '0;
   logic          res_valid;
   logic [7:0]    res_type;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   memtype_resolver u_memtype_resolver (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .req_valid(req_valid), .req_start(req_start),
      .req_end(req_end), .res_valid(res_valid), .res_type(res_type)
   );

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic wr(input int sel, input logic [63:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 6'(sel); wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic lookup(input string tag, input logic [AW-1:0] s,
                         input logic [AW-1:0] e, input logic [7:0] exp);
      @(negedge clk);
      req_valid = 1'b1; req_start = s; req_end = e;
      @(negedge clk);
      req_valid = 1'b0;
      check({tag, " valid"}, {7'd0, res_valid}, 8'd1);
      check(tag, res_type, exp);
   endtask

   function automatic logic [63:0] mk_mask(input logic [63:0] sz);
      return ((~(sz - 64'd1)) & 64'h0000_FFFF_FFFF_F000) | 64'h800;
   endfunction

   task automatic set_range(input int i, input logic [63:0] base,
                            input logic [63:0] sz, input logic [7:0] t, input bit on);
      wr(32 + 2*i, base | 64'(t));
      wr(33 + 2*i, on ? mk_mask(sz) : (mk_mask(sz) & ~64'h800));
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R13 reset valid", {7'd0, res_valid}, 8'd0);
      check("R13 reset type", res_type, 8'hFF);
   endtask

   task automatic t_off();
      lookup("R1 unprogrammed", 48'h2000_0000, 48'h2000_1000, 8'hFF);
      wr(0, 64'h006);
      lookup("R1 enables clear", 48'h2000_0000, 48'h2000_1000, 8'hFF);
   endtask

   task automatic t_fixed();
      for (int k = 0; k < 11; k++) begin
         logic [63:0] w;
         for (int j = 0; j < 8; j++) w[j*8 +: 8] = 8'(8*k + j);
         wr(2 + k, w);
      end
      wr(0, 64'h406);
      lookup("R3 64K entry3", 48'h3_0000, 48'h80_0000, 8'd3);
      lookup("R3 16K entry9", 48'h8_4000, 48'h8_5000, 8'd9);
      lookup("R3 16K entry23", 48'hB_C000, 48'hB_D000, 8'd23);
      lookup("R3 4K entry25", 48'hC_1000, 48'hC_2000, 8'd25);
      lookup("R3 4K entry87", 48'hF_F000, 48'h10_0000, 8'd87);
      lookup("R4 ranges off default", 48'h10_0000, 48'h10_1000, 8'd6);
   endtask

   task automatic t_ranges();
      wr(0, 64'hC06);
      set_range(0, 64'h1000_0000, 64'h10_0000, 8'd1, 1'b1);
      set_range(1, 64'h3000_0000, 64'h10_0000, 8'd0, 1'b0);
      set_range(2, 64'h4000_0000, 64'h10_0000, 8'd6, 1'b1);
      set_range(3, 64'h4000_0000, 64'h10_0000, 8'd4, 1'b1);
      set_range(4, 64'h5000_0000, 64'h10_0000, 8'd1, 1'b1);
      set_range(5, 64'h5000_0000, 64'h10_0000, 8'd6, 1'b1);
      set_range(6, 64'h6000_0000, 64'h10_0000, 8'd6, 1'b1);
      set_range(7, 64'h6000_0000, 64'h10_0000, 8'd0, 1'b1);
      lookup("R5 R6 single match exact end", 48'h1000_0000, 48'h1010_0000, 8'd1);
      lookup("R5 low bits ignored", 48'h1000_0800, 48'h1000_0900, 8'd1);
      lookup("R7 straddle", 48'h1000_0000, 48'h1010_0001, 8'hFE);
      lookup("R12 no match", 48'h2000_0000, 48'h2000_1000, 8'd6);
      lookup("R5 valid bit clear", 48'h3000_0000, 48'h3000_1000, 8'd6);
      lookup("R9 WB with WT", 48'h4000_0000, 48'h4000_1000, 8'd4);
      lookup("R10 WC with WB", 48'h5000_0000, 48'h5000_1000, 8'd0);
      lookup("R8 UC wins", 48'h6000_0000, 48'h6000_1000, 8'd0);
   endtask

   task automatic t_limit();
      wr(0, 64'hC00);
      wr(1, 64'h2_0000_0000);
      set_range(0, 64'h1_0000_0000, 64'h10_0000, 8'd1, 1'b1);
      lookup("R11 limit overrides match", 48'h1_0000_0000, 48'h1_0000_1000, 8'd6);
      lookup("R7 partial beats limit", 48'h1_0000_0000, 48'h1_0010_0001, 8'hFE);
      lookup("R11 limit no match", 48'h1_4000_0000, 48'h1_4000_1000, 8'd6);
      lookup("R11 below 4G", 48'hFFFF_F000, 48'h1_0000_0000, 8'd0);
      lookup("R11 end reaches limit", 48'h1_F000_0000, 48'h2_0000_0001, 8'd0);
      wr(1, 64'h1_807F_FFFF);
      lookup("R11 low limit bits dropped", 48'h1_8000_0000, 48'h1_8000_1000, 8'd0);
   endtask

   task automatic t_hold();
      lookup("R2 seed", 48'h1_0000_0000, 48'h1_0000_1000, 8'd6);
      @(negedge clk);
      req_start = 48'h2000_0000; req_end = 48'h2000_1000;
      repeat (3) @(negedge clk);
      check("R2 held type", res_type, 8'd6);
      check("R2 no strobe", {7'd0, res_valid}, 8'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_off();
      t_fixed();
      t_ranges();
      t_limit();
      t_hold();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule